// File: doc/BRIEF.md
# Page Translation Configuration Slave

This block is a memory-mapped register slave on an AXI4-Lite port that owns a page translation table. Software loads the table one entry at a time: it places a virtual address in the address register, puts a 16-bit physical page number together with a store flag in the page register, and then clears the flag again. While the store flag is clear, the block translates all the time. The upper half of the virtual address selects a table entry. That entry becomes the upper half of the outgoing address, and the lower 16 bits (the page offset) pass through unchanged.

Alongside the translated address, the block also presents a 32-bit data word and a start level. A write engine next to it uses these three values to carry out the actual memory write at the translated location. All registers clear on reset. The table is never cleared, so an entry that was never loaded reads back as an undefined value.

The table depth is a parameter. The index is the low `TBL_IDX_W` bits of virtual address bits 31:16, and any higher index bits alias onto the same entry. The default depth is kept small. Setting `TBL_IDX_W` to 16 gives the full 65536-entry table.

Top module: `xlat_cfg_slave`

## Requirements
- R1: After reset, all four registers read back as zero, `wr_data_o` is 0, `start_o` is 0, and neither `s_bvalid_o` nor `s_rvalid_o` is asserted.
- R2: A register write updates only the bytes whose `s_wstrb_i` bit is set. Strobe bit n covers data bits 8n+7:8n.
- R3: The register is selected by address bits 3:2: 0 = virtual address, 1 = page register, 2 = start register, 3 = data register. All other address bits are ignored. A read returns the stored contents. Page register bits 31:17 and start register bits 31:1 always read as zero.
- R4: Every write gets exactly one response with `s_bresp_o` = 2'b00. Every read returns `s_rresp_o` = 2'b00. A pending response holds until it is accepted. No new write is accepted while a write response is pending.
- R5: While page register bit 16 is set, the table entry selected by the virtual address is written with page register bits 15:0 on every clock edge. While that bit is clear, the table is not changed.
- R6: `xlat_addr_o` is {table entry selected by virtual address bits 31:16, virtual address bits 15:0}.
- R7: The lower half of `xlat_addr_o` follows a new virtual address in the cycle it is written. The upper half follows one clock later.
- R8: `wr_data_o` equals the data register, and `start_o` equals start register bit 0.
- R9: Only the low `TBL_IDX_W` bits of virtual address bits 31:16 select the entry. Indices that differ only above those bits reach the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_awaddr_i | input | AXI_AW | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte enables |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | AXI_AW | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| xlat_addr_o | output | 32 | Translated address |
| wr_data_o | output | 32 | Data word for the write engine |
| start_o | output | 1 | Start level for the write engine |

## Verification
The hardest case to reach is showing that a table entry survives when software rewrites the page value while the store flag is clear. The table cannot be read directly. The stimulus therefore loads an entry, clears the flag, writes a different page value, and steers the virtual address away from the entry and back onto it. The upper half of the translated address must still show the original entry. The one-clock lag of the upper half is caught by sampling the translated address in the cycle right after the address register write completes, before the write response is accepted.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned PAGE_W = 16;
  localparam logic [1:0]  RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    SEL_VIRT = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_GO   = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] merge_bytes(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [STRB_W-1:0] strb
  );
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) r[8*b +: 8] = new_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
  import xlat_pkg::*;
#(
  parameter int unsigned AXI_AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AXI_AW-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [DATA_W-1:0] s_wdata_i,
  input  logic [STRB_W-1:0] s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [AXI_AW-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic [DATA_W-1:0] virt_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              store_o,
  output logic              go_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned PAGE_REG_W = PAGE_W + 1;

  logic [DATA_W-1:0]     virt_q, data_q;
  logic [PAGE_REG_W-1:0] page_q;
  logic                  go_q;
  logic                  bvalid_q, rvalid_q;
  logic [DATA_W-1:0]     rdata_q;
  logic                  wr_hs, rd_hs;
  reg_sel_e              wsel, rsel;
  logic [DATA_W-1:0]     rd_mux;

  // address and data are taken together; no skid storage
  assign wr_hs = s_awvalid_i && s_wvalid_i && !bvalid_q;
  assign rd_hs = s_arvalid_i && !rvalid_q;
  assign wsel  = reg_sel_e'(s_awaddr_i[3:2]);
  assign rsel  = reg_sel_e'(s_araddr_i[3:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      virt_q <= '0;
      page_q <= '0;
      go_q   <= 1'b0;
      data_q <= '0;
    end else if (wr_hs) begin
      unique case (wsel)
        SEL_VIRT: virt_q <= merge_bytes(virt_q, s_wdata_i, s_wstrb_i);
        SEL_PAGE: page_q <= PAGE_REG_W'(merge_bytes(DATA_W'(page_q), s_wdata_i, s_wstrb_i));
        SEL_GO:   go_q   <= s_wstrb_i[0] ? s_wdata_i[0] : go_q;
        SEL_DATA: data_q <= merge_bytes(data_q, s_wdata_i, s_wstrb_i);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              bvalid_q <= 1'b0;
    else if (wr_hs)           bvalid_q <= 1'b1;
    else if (s_bready_i)      bvalid_q <= 1'b0;
  end

  always_comb begin
    unique case (rsel)
      SEL_VIRT: rd_mux = virt_q;
      SEL_PAGE: rd_mux = DATA_W'(page_q);
      SEL_GO:   rd_mux = DATA_W'(go_q);
      SEL_DATA: rd_mux = data_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_hs) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_mux;
    end else if (s_rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign s_awready_o = wr_hs;
  assign s_wready_o  = wr_hs;
  assign s_bvalid_o  = bvalid_q;
  assign s_bresp_o   = RESP_OKAY;
  assign s_arready_o = !rvalid_q;
  assign s_rvalid_o  = rvalid_q;
  assign s_rdata_o   = rdata_q;
  assign s_rresp_o   = RESP_OKAY;

  assign virt_o  = virt_q;
  assign page_o  = page_q[PAGE_W-1:0];
  assign store_o = page_q[PAGE_W];
  assign go_o    = go_q;
  assign data_o  = data_q;

  logic unused_addr;
  assign unused_addr = ^{s_awaddr_i[AXI_AW-1:4], s_awaddr_i[1:0],
                         s_araddr_i[AXI_AW-1:4], s_araddr_i[1:0]};

  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o) else $error("bvalid dropped"); // R4
  AST_NO_AW_WHILE_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o |-> !s_awready_o) else $error("write taken with response pending"); // R4
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o)) else $error("read data not held"); // R4
endmodule

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned ENTRY_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  output logic [ENTRY_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]   rd_idx_q;

  // contents are deliberately not reset
  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_idx_q <= '0;
    else         rd_idx_q <= idx_i;
  end

  assign rdata_o = mem[rd_idx_q];

  AST_TBL_WRITE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (idx_i == rd_idx_q) |=> rdata_o == $past(wdata_i)) else $error("stored entry not visible"); // R5
endmodule

// File: rtl/xlat_cfg_slave.sv
module xlat_cfg_slave
  import xlat_pkg::*;
#(
  parameter int unsigned AXI_AW    = 32,
  parameter int unsigned TBL_IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AXI_AW-1:0] s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [31:0]       s_wdata_i,
  input  logic [3:0]        s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [AXI_AW-1:0] s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [31:0]       s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic [31:0]       xlat_addr_o,
  output logic [31:0]       wr_data_o,
  output logic              start_o
);
  logic [DATA_W-1:0]    virt;
  logic [PAGE_W-1:0]    page;
  logic                 store;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [PAGE_W-1:0]    tbl_rdata;

  xlat_regs #(.AXI_AW(AXI_AW)) u_regs (
    .clk_i, .rst_ni,
    .s_awaddr_i, .s_awvalid_i, .s_awready_o,
    .s_wdata_i, .s_wstrb_i, .s_wvalid_i, .s_wready_o,
    .s_bresp_o, .s_bvalid_o, .s_bready_i,
    .s_araddr_i, .s_arvalid_i, .s_arready_o,
    .s_rdata_o, .s_rresp_o, .s_rvalid_o, .s_rready_i,
    .virt_o (virt),
    .page_o (page),
    .store_o(store),
    .go_o   (start_o),
    .data_o (wr_data_o)
  );

  assign tbl_idx = virt[PAGE_W +: TBL_IDX_W];

  generate
    if (TBL_IDX_W < PAGE_W) begin : g_alias
      logic unused_hi_idx;
      assign unused_hi_idx = ^virt[DATA_W-1:PAGE_W+TBL_IDX_W];
    end
  endgenerate

  xlat_table #(.IDX_W(TBL_IDX_W), .ENTRY_W(PAGE_W)) u_table (
    .clk_i, .rst_ni,
    .we_i   (store),
    .idx_i  (tbl_idx),
    .wdata_i(page),
    .rdata_o(tbl_rdata)
  );

  assign xlat_addr_o = {tbl_rdata, virt[PAGE_W-1:0]};

  AST_OFFSET_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_awready_o && s_awaddr_i[3:2] == 2'd0 && s_wstrb_i[1:0] == 2'b11
    |=> xlat_addr_o[15:0] == $past(s_wdata_i[15:0])) else $error("offset not passed"); // R6
endmodule

// File: tb/xlat_cfg_slave_tb.sv
`timescale 1ns/1ps
module xlat_cfg_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] awaddr = '0, araddr = '0, wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic awready, wready, bvalid, arready, rvalid, start;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata, xlat, wrd;

  int checks = 0, errors = 0;
  logic [31:0] snap;

  xlat_cfg_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
    .xlat_addr_o(xlat), .wr_data_o(wrd), .start_o(start)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    #0.5;
    while (!(awready && wready)) begin @(negedge clk); #0.5; end
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    snap = xlat;
    check("R4 bvalid", {31'b0, bvalid}, 32'd1);
    check("R4 bresp", {30'b0, bresp}, 32'd0);
    @(negedge clk);
    check("R4 bvalid held", {31'b0, bvalid}, 32'd1);
    bready = 1;
    @(negedge clk);
    bready = 0;
    check("R4 single response", {31'b0, bvalid}, 32'd0);
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1;
    #0.5;
    while (!arready) begin @(negedge clk); #0.5; end
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    d = rdata;
    check("R4 rvalid", {31'b0, rvalid}, 32'd1);
    check("R4 rresp", {30'b0, rresp}, 32'd0);
    rready = 1;
    @(negedge clk);
    rready = 0;
  endtask

  task automatic store_entry(input logic [15:0] idx, input logic [15:0] pg);
    wr(32'h0, {idx, 16'h0000});
    wr(32'h4, {15'b0, 1'b1, pg});
    wr(32'h4, {16'h0, pg});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 bvalid", {31'b0, bvalid}, 32'd0);
    check("R1 rvalid", {31'b0, rvalid}, 32'd0);
    check("R1 start", {31'b0, start}, 32'd0);
    check("R1 wr_data", wrd, 32'd0);
    for (int i = 0; i < 4; i++) begin
      rd(32'(i * 4), v);
      check("R1 reg zero", v, 32'd0);
    end
  endtask

  task automatic t_strobe;
    logic [31:0] v;
    wr(32'hC, 32'hA5A5A5A5);
    wr(32'hC, 32'h11223344, 4'b0101);
    rd(32'hC, v);
    check("R2 strobe merge", v, 32'hA522A544);
    check("R8 wr_data", wrd, 32'hA522A544);
    wr(32'hC, 32'hFFFFFFFF, 4'b0000);
    rd(32'hC, v);
    check("R2 no strobe", v, 32'hA522A544);
  endtask

  task automatic t_decode;
    logic [31:0] v;
    wr(32'h4, 32'hFFFFFFFF);
    rd(32'h4, v);
    check("R3 page reg mask", v, 32'h0001FFFF);
    wr(32'h4, 32'h0);
    wr(32'h8, 32'hFFFFFFFF);
    rd(32'h8, v);
    check("R3 start reg mask", v, 32'h1);
    check("R8 start high", {31'b0, start}, 32'd1);
    wr(32'h8, 32'h0);
    check("R8 start low", {31'b0, start}, 32'd0);
    wr(32'hF0_0032, 32'h0BAD_CAFE);
    rd(32'h0, v);
    check("R3 upper addr bits ignored", v, 32'h0BADCAFE);
    rd(32'h123_4001, v);
    check("R3 read alias", v, 32'h0BADCAFE);
  endtask

  task automatic t_translate;
    store_entry(16'h0012, 16'hBEEF);
    store_entry(16'h0034, 16'h1234);
    wr(32'h0, 32'h0012_5678);
    check("R6 translate a", xlat, 32'hBEEF5678);
    wr(32'h0, 32'h0034_0001);
    check("R6 translate b", xlat, 32'h12340001);
  endtask

  task automatic t_latency;
    wr(32'h0, 32'h0012_ABCD);
    check("R7 first cycle", snap, 32'h1234ABCD);
    check("R7 settled", xlat, 32'hBEEFABCD);
  endtask

  task automatic t_store_off;
    wr(32'h4, 32'h0000_7777);
    wr(32'h0, 32'h0034_0000);
    wr(32'h0, 32'h0012_0002);
    check("R5 no write while clear", xlat, 32'hBEEF0002);
    wr(32'h0, 32'h0034_0003);
    check("R5 other entry intact", xlat, 32'h12340003);
  endtask

  task automatic t_alias;
    wr(32'h0, 32'h0112_0004);
    check("R9 index alias", xlat, 32'hBEEF0004);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_strobe();
    t_decode();
    t_translate();
    t_latency();
    t_store_off();
    t_alias();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule